// File: doc/BRIEF.md
# Robbed-Bit Signaling Monitor

This block watches the received octet stream of a 24-channel T1 line and extracts the robbed signaling bit of every channel. The robbed bit is bit 0 of a channel octet in the sixth frame of each six-frame group. The framer in front of it supplies every octet together with its channel number (0..23) and its frame position (0..23) inside a 24-frame signaling period. The monitor collects the bits of one period in a hidden buffer. At the end of the period it copies the buffer into twelve visible 8-bit registers all at once, so a read never sees part of two periods.

Two line formats are supported. In extended-superframe mode each channel yields four bits (A, B, C, D) per period. In 12-frame mode the period covers two superframes, and each channel yields an A,B pair from each of them. At every period boundary the new set is compared with the set already on display. A difference raises a sticky change interrupt, and every refresh raises a sticky update flag. The host must read the registers within one period, about 3 ms, because the next boundary overwrites them. It reads them through a small address-mapped port. That read returns zero while the serial signaling path is enabled.

Top module: `rbs_monitor`

## Requirements
- R1: With `fmt_esf`=1, bit 0 of the octet of channel c (0..23) in frame 5, 11, 17 or 23 is bit A, B, C or D (q = 0..3) of that channel. It lands in register c/2 at bit 7-(4*(c%2)+q). Register k sits at `sig_regs[8k+7:8k]`.
- R2: With `fmt_esf`=0, frames 5 and 11 give A and B of the first superframe, and frames 17 and 23 give A and B of the second. Registers 0..5 hold the first superframe and registers 6..11 the second. In register s*6+j, channel 4j+i occupies bits 7-2i (A) and 6-2i (B).
- R3: Bits 7..1 of every octet, bit 0 of octets in all other frames, and octets with `oct_vld`=0 leave the registers unchanged.
- R4: The visible registers keep their previous values until the period ends. The period ends with the valid octet of channel 23 in frame 23, and all twelve registers change on the clock edge that takes that octet.
- R5: When a refreshed set differs from the set it replaces, `sig_chg_irq` goes to 1 on that same edge. It stays at 1 through later periods until it is cleared.
- R6: A refresh with a set equal to the previous one leaves `sig_chg_irq` at 0.
- R7: A read at address 12 returns {6'b0, `sig_upd`, `sig_chg_irq`}, and on that clock edge it clears both flags. A set on the same edge wins.
- R8: No refresh and no interrupt happen until one period has been received from frame 0 channel 0 onward. The first complete period refreshes the registers and raises only `sig_upd`.
- R9: Every refresh sets `sig_upd` on the edge that loads the registers.
- R10: While `ser_sig_en`=1, reads at addresses 0..11 return 0x00, and the status address still reads normally. While `ser_sig_en`=0, address k returns register k.
- R11: After reset `sig_chg_irq` and `sig_upd` are 0, and the status read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oct_vld | input | 1 | Octet strobe |
| oct_data | input | 8 | Received channel octet |
| oct_chan | input | 5 | Channel number 0..23 |
| oct_frame | input | 5 | Frame position 0..23 within the period |
| fmt_esf | input | 1 | 1 = extended superframe, 0 = 12-frame superframe |
| ser_sig_en | input | 1 | Serial signaling output enabled; blanks register reads |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | 0..11 registers, 12 status |
| rd_data | output | 8 | Read data, combinational from address |
| sig_regs | output | 96 | Twelve visible registers, register k at bits 8k+7..8k |
| sig_chg_irq | output | 1 | Sticky signaling-changed interrupt |
| sig_upd | output | 1 | Sticky register-refresh flag |

## Verification
A wrong bit position in the shadow buffer shows up at the next period boundary as one wrong bit in a named register. A lost or mistimed boundary shows up as registers that still hold the old set on the cycle after the last octet. A bad compare or a bad history flag shows up in the interrupt on that same edge, either missing on a one-bit change or present on a repeated set. A stuck flag shows up on the read that follows a status clear.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int NUM_CH     = 24;
  localparam int FRAMES     = 24;
  localparam int SIG_PER_CH = 4;
  localparam int REG_W      = 8;
  localparam int TOT_BITS   = NUM_CH * SIG_PER_CH;
  localparam int NUM_REG    = TOT_BITS / REG_W;
  localparam int FR_STRIDE  = FRAMES / SIG_PER_CH;
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int FR_W       = $clog2(FRAMES);
  localparam int IDX_W      = $clog2(TOT_BITS);
  localparam int ADDR_W     = $clog2(NUM_REG + 1);
  localparam int STAT_ADDR  = NUM_REG;

  typedef logic [TOT_BITS-1:0] sig_set_t;
endpackage

// File: rtl/rbs_pos_map.sv
module rbs_pos_map
  import rbs_pkg::*;
(
  input  logic             oct_vld,
  input  logic             rob_bit,
  input  logic [CH_W-1:0]  oct_chan,
  input  logic [FR_W-1:0]  oct_frame,
  input  logic             fmt_esf,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_bit,
  output logic             period_start,
  output logic             period_end
);
  logic       in_range;
  logic       sig_frame;
  logic [1:0] slot;
  int         pos;

  always_comb begin
    in_range  = (oct_chan < CH_W'(NUM_CH)) && (oct_frame < FR_W'(FRAMES));
    sig_frame = (int'(oct_frame) % FR_STRIDE) == (FR_STRIDE - 1);
    slot      = 2'(int'(oct_frame) / FR_STRIDE);
    if (fmt_esf)
      pos = int'(oct_chan) * SIG_PER_CH + int'(slot);
    else
      pos = int'(slot[1]) * (TOT_BITS / 2) + int'(oct_chan) * 2 + int'(slot[0]);
    // sequential bit order runs from bit 7 downward inside each register
    wr_idx       = IDX_W'((pos / REG_W) * REG_W + (REG_W - 1) - (pos % REG_W));
    wr_bit       = rob_bit;
    wr_en        = oct_vld && in_range && sig_frame;
    period_start = oct_vld && (oct_chan == '0) && (oct_frame == '0);
    period_end   = oct_vld && (oct_chan == CH_W'(NUM_CH - 1)) &&
                   (oct_frame == FR_W'(FRAMES - 1));
  end
endmodule

// File: rtl/rbs_shadow.sv
module rbs_shadow
  import rbs_pkg::*;
(
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  output sig_set_t         snap
);
  sig_set_t shadow_q;
  sig_set_t shadow_d;

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en) shadow_d[wr_idx] = wr_bit;
  end

  // data store, no reset: content is undefined until a period completes
  always_ff @(posedge clk) begin
    if (wr_en) shadow_q <= shadow_d;
  end

  assign snap = shadow_d;
endmodule

// File: rtl/rbs_bank.sv
module rbs_bank
  import rbs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sig_set_t snap,
  input  logic     period_start,
  input  logic     period_end,
  input  logic     clr,
  output sig_set_t vis_q,
  output logic     chg_irq_q,
  output logic     upd_q
);
  logic started_q, started_d;
  logic hist_q, hist_d;
  logic chg_irq_d, upd_d;
  logic load, set_irq;

  always_comb begin
    load      = period_end && started_q;
    set_irq   = load && hist_q && (snap != vis_q);
    started_d = started_q || period_start;
    hist_d    = hist_q || load;
    chg_irq_d = set_irq || (chg_irq_q && !clr);
    upd_d     = load || (upd_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      hist_q    <= 1'b0;
      chg_irq_q <= 1'b0;
      upd_q     <= 1'b0;
    end else begin
      started_q <= started_d;
      hist_q    <= hist_d;
      chg_irq_q <= chg_irq_d;
      upd_q     <= upd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) vis_q <= snap;
  end

  p_vis_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(vis_q));
  p_irq_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_irq_q) |-> $past(period_end));
  p_same_set_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && (snap == vis_q) && !chg_irq_q) |=> !chg_irq_q);
  p_status_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !period_end) |=> (!chg_irq_q && !upd_q));
  p_no_irq_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_q |-> !chg_irq_q);
  p_upd_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_q) |-> $past(period_end));
endmodule

// File: rtl/rbs_monitor.sv
module rbs_monitor
  import rbs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                oct_vld,
  input  logic [REG_W-1:0]    oct_data,
  input  logic [CH_W-1:0]     oct_chan,
  input  logic [FR_W-1:0]     oct_frame,
  input  logic                fmt_esf,
  input  logic                ser_sig_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [REG_W-1:0]    rd_data,
  output logic [TOT_BITS-1:0] sig_regs,
  output logic                sig_chg_irq,
  output logic                sig_upd
);
  logic             wr_en, wr_bit, period_start, period_end, clr;
  logic [IDX_W-1:0] wr_idx;
  sig_set_t         snap, vis;
  logic             unused_hi;

  assign unused_hi = ^oct_data[REG_W-1:1];

  rbs_pos_map i_pos_map (
    .oct_vld      (oct_vld),
    .rob_bit      (oct_data[0]),
    .oct_chan     (oct_chan),
    .oct_frame    (oct_frame),
    .fmt_esf      (fmt_esf),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_bit       (wr_bit),
    .period_start (period_start),
    .period_end   (period_end)
  );

  rbs_shadow i_shadow (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_bit (wr_bit),
    .snap   (snap)
  );

  assign clr = rd_en && (rd_addr == ADDR_W'(STAT_ADDR));

  rbs_bank i_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .snap         (snap),
    .period_start (period_start),
    .period_end   (period_end),
    .clr          (clr),
    .vis_q        (vis),
    .chg_irq_q    (sig_chg_irq),
    .upd_q        (sig_upd)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(STAT_ADDR))
      rd_data = {{(REG_W-2){1'b0}}, sig_upd, sig_chg_irq};
    else if ((rd_addr < ADDR_W'(NUM_REG)) && !ser_sig_en)
      rd_data = vis[int'(rd_addr)*REG_W +: REG_W];
  end

  assign sig_regs = vis;
endmodule

// File: tb/test_rbs_monitor.sv
`timescale 1ns/1ps
module test_rbs_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        oct_vld;
  logic [7:0]  oct_data;
  logic [4:0]  oct_chan;
  logic [4:0]  oct_frame;
  logic        fmt_esf;
  logic        ser_sig_en;
  logic        rd_en;
  logic [3:0]  rd_addr;
  logic [7:0]  rd_data;
  logic [95:0] sig_regs;
  logic        sig_chg_irq;
  logic        sig_upd;

  int n_chk = 0;
  int n_err = 0;
  logic [3:0] pat [24];

  always #10 clk = ~clk;

  rbs_monitor i_rbs_monitor (
    .clk(clk), .rst_n(rst_n), .oct_vld(oct_vld), .oct_data(oct_data),
    .oct_chan(oct_chan), .oct_frame(oct_frame), .fmt_esf(fmt_esf),
    .ser_sig_en(ser_sig_en), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .sig_regs(sig_regs), .sig_chg_irq(sig_chg_irq),
    .sig_upd(sig_upd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] octet(int ch, int f, bit noise);
    logic b;
    logic [6:0] hi;
    if (f % 6 == 5) b = pat[ch][3 - f/6];
    else            b = noise ? 1'((ch ^ f) & 1) : 1'b0;
    hi = noise ? 7'((ch*29 + f*7) & 127) : 7'd0;
    return {hi, b};
  endfunction

  function automatic logic [7:0] exp_reg(int k, bit esf);
    logic [7:0] r;
    if (esf) r = {pat[2*k], pat[2*k+1]};
    else begin
      for (int i = 0; i < 4; i++) begin
        int ch = (k % 6) * 4 + i;
        r[7-2*i -: 2] = (k >= 6) ? pat[ch][1:0] : pat[ch][3:2];
      end
    end
    return r;
  endfunction

  task automatic send(int f0, int f1, bit noise);
    for (int f = f0; f <= f1; f++)
      for (int ch = 0; ch < 24; ch++) begin
        @(negedge clk);
        oct_vld = 1'b1; oct_chan = 5'(ch); oct_frame = 5'(f);
        oct_data = octet(ch, f, noise);
      end
    @(negedge clk);
    oct_vld = 1'b0; oct_data = 8'hFF;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #2 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_regs(string req, bit esf);
    for (int k = 0; k < 12; k++)
      chk(req, 32'(sig_regs[k*8 +: 8]), 32'(exp_reg(k, esf)));
  endtask

  task automatic set_pat(int seed);
    for (int ch = 0; ch < 24; ch++) pat[ch] = 4'(ch*5 + seed);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 irq", 32'(sig_chg_irq), 0);
    chk("R11 upd", 32'(sig_upd), 0);
    rd(4'd12, d);
    chk("R11 status", 32'(d), 0);
  endtask

  task automatic t_first_period();
    logic [7:0] d;
    set_pat(3);
    send(12, 23, 1'b0);
    chk("R8 partial upd", 32'(sig_upd), 0);
    chk("R8 partial irq", 32'(sig_chg_irq), 0);
    send(0, 23, 1'b0);
    chk_regs("R1 esf layout", 1'b1);
    chk("R9 upd", 32'(sig_upd), 1);
    chk("R8 first irq", 32'(sig_chg_irq), 0);
    rd(4'd12, d);
    chk("R7 status", 32'(d), 32'h02);
    rd(4'd12, d);
    chk("R7 cleared", 32'(d), 32'h00);
  endtask

  task automatic t_same_then_change();
    logic [7:0] d;
    send(0, 23, 1'b0);
    chk("R6 same irq", 32'(sig_chg_irq), 0);
    chk("R9 upd again", 32'(sig_upd), 1);
    rd(4'd12, d);
    pat[23] = pat[23] ^ 4'h1;
    send(0, 22, 1'b0);
    chk("R4 hold reg11", 32'(sig_regs[95:88]), 32'(exp_reg(11, 1'b1) ^ 8'h01));
    chk("R4 no irq yet", 32'(sig_chg_irq), 0);
    send(23, 23, 1'b0);
    chk("R4 reg11 now", 32'(sig_regs[95:88]), 32'(exp_reg(11, 1'b1)));
    chk("R5 irq set", 32'(sig_chg_irq), 1);
    send(0, 23, 1'b0);
    chk("R5 sticky", 32'(sig_chg_irq), 1);
    rd(4'd12, d);
    chk("R7 both flags", 32'(d), 32'h03);
    chk("R7 irq clr", 32'(sig_chg_irq), 0);
  endtask

  task automatic t_noise();
    logic [7:0] d;
    send(0, 23, 1'b1);
    chk_regs("R3 noise", 1'b1);
    chk("R3 no irq", 32'(sig_chg_irq), 0);
    rd(4'd12, d);
  endtask

  task automatic t_sf12();
    logic [7:0] d;
    fmt_esf = 1'b0;
    set_pat(7);
    send(0, 23, 1'b0);
    chk_regs("R2 sf layout", 1'b0);
    rd(4'd12, d);
    rd(4'd6, d);
    chk("R10 read reg6", 32'(d), 32'(exp_reg(6, 1'b0)));
  endtask

  task automatic t_serial();
    logic [7:0] d;
    ser_sig_en = 1'b1;
    rd(4'd0, d);
    chk("R10 blanked", 32'(d), 0);
    rd(4'd12, d);
    chk("R10 status readable", 32'(d), 0);
    ser_sig_en = 1'b0;
    rd(4'd0, d);
    chk("R10 reg0", 32'(d), 32'(exp_reg(0, 1'b0)));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; oct_vld = 1'b0; oct_data = '0; oct_chan = '0; oct_frame = '0;
    fmt_esf = 1'b1; ser_sig_en = 1'b0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_period();
    t_same_then_change();
    t_noise();
    t_sf12();
    t_serial();
    finish_run();
  end
endmodule